// File: doc/BRIEF.md
# Double-Buffered DMA Descriptor Controller

This block holds the descriptors for a scatter-gather DMA engine. Software places a pending transfer (word count, start address, direction) into a staging slot while the engine is still working on the active one. A start bit in the control word marks the staged descriptor as valid. When the engine is idle, the block copies the staged descriptor into the active count and address registers. It then pulses a load strobe, and the staging slot is free to take the next descriptor.

The transfer engine sends one pulse per word moved. On each pulse the active count steps down and the active address steps up. A transfer ends when the count reaches zero, and any staged descriptor is handed over on the following clock. Software can abort at any time. An abort drops both the active transfer and the staged one.

Two events can set a single sticky interrupt flag, and each has its own enable: the staged descriptor being taken, and a transfer completing. The flag reaches the interrupt pin only when a global interrupt enable is also set. The register map has four word slots: control word (0), staged address (1), interrupt flag (2) and interrupt configuration (3).

Top module: `dma_desc_ctrl`

## Requirements
- R1: After reset, xfer_load and irq are 0 and xfer_count is 0. The control word reads 0x6000_0000: bit 29 (slot free) and bit 30 (engine idle) are 1, and every other bit is 0.
- R2: While control bit 29 reads 1, a control write stores bits 15:0 as the staged count and bit 25 as the staged direction (1 = memory read, 0 = memory write). A write to slot 1 stores the staged address. A control write with bit 29 set marks the staged descriptor valid, and bit 29 then reads 0.
- R3: While control bit 29 reads 0, writes to the staged count, the staged direction, the staged address and the start bit have no effect.
- R4: On the first clock edge where a staged descriptor is valid and the engine is idle, xfer_count, xfer_addr and xfer_rd take the staged values and xfer_load is 1 for exactly one cycle. From then on, bit 29 reads 1.
- R5: On each xfer_word pulse while a transfer is active, xfer_count drops by 1 and xfer_addr rises by ADDR_STEP (default 4). A pulse while idle changes nothing.
- R6: Bit 30 reads 0 while a transfer is active. It reads 1 after the edge where the count reaches zero, and a descriptor loaded with count 0 completes at once. A descriptor staged during a transfer is loaded on the clock edge after completion.
- R7: A control write with bit 26 set stops the active transfer and discards the staged descriptor. It raises no completion event, and no load follows it. Afterwards bits 29 and 30 read 1 and bit 26 reads 0.
- R8: The take event sets the interrupt flag (slot 2 bit 0) only when control bit 31 is 1. The completion event sets it only when control bit 27 is 1. Writing 1 to slot 2 bit 0 clears the flag, writing 0 leaves it, and a set in the same cycle wins over a clear.
- R9: irq is 1 exactly when the interrupt flag is 1 and slot 3 bit 0 (global enable) is 1.
- R10: Control bits 31, 28 and 27 are written by every control write, even while the staged slot is locked, and they read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word slot |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| xfer_load | output | 1 | One-cycle pulse: new active descriptor loaded |
| xfer_count | output | 16 | Active remaining word count |
| xfer_addr | output | 32 | Active transfer address |
| xfer_word | input | 1 | One word moved by the engine |
| xfer_rd | output | 1 | Active direction, 1 = memory read |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check four things: the staged address stays fixed while the slot is locked, a valid staged descriptor meeting an idle engine always yields a single load pulse, the active count changes only on word pulses, and an abort leaves neither a transfer nor a staged descriptor behind. They also check that a clear of the interrupt flag with no event pending takes effect. Only the bench scenarios can show the values themselves: the loaded count, address and direction, the final address after a run, which enable lets which event set the flag, the ordering of a queued descriptor behind a running one, and the readback of the control bits.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;

    localparam int CNT_W = 16;
    localparam int AW    = 32;

    localparam int B_EN_TAKE = 31;
    localparam int B_IDLE    = 30;
    localparam int B_START   = 29;
    localparam int B_EN_PAGE = 28;
    localparam int B_EN_DONE = 27;
    localparam int B_ABORT   = 26;
    localparam int B_DIR     = 25;

    typedef enum logic [1:0] {
        RA_CTRL  = 2'd0,
        RA_NADDR = 2'd1,
        RA_ISTAT = 2'd2,
        RA_ICFG  = 2'd3
    } reg_slot_e;

    typedef struct packed {
        logic             valid;
        logic [CNT_W-1:0] cnt;
        logic [AW-1:0]    addr;
        logic             dir;
        logic             en_take;
        logic             en_page;
        logic             en_done;
    } pend_s;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [AW-1:0]    addr;
        logic             dir;
        logic             load;
    } act_s;

    typedef struct packed {
        logic flag;
        logic gie;
    } irq_s;

endpackage

// File: rtl/dma_pend_slot.sv
module dma_pend_slot
    import dma_desc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic             wr_naddr,
    input  logic             w_start,
    input  logic             w_dir,
    input  logic [CNT_W-1:0] w_cnt,
    input  logic             w_en_take,
    input  logic             w_en_page,
    input  logic             w_en_done,
    input  logic [AW-1:0]    w_addr,
    input  logic             abort,
    input  logic             take,
    output pend_s            pend
);

    pend_s pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (wr_ctrl) begin
            pend_d.en_take = w_en_take;
            pend_d.en_page = w_en_page;
            pend_d.en_done = w_en_done;
        end
        if (!pend_q.valid) begin
            if (wr_ctrl) begin
                pend_d.cnt = w_cnt;
                pend_d.dir = w_dir;
                if (w_start && !abort)
                    pend_d.valid = 1'b1;
            end
            if (wr_naddr)
                pend_d.addr = w_addr;
        end
        if (take || abort)
            pend_d.valid = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;

endmodule

// File: rtl/dma_active_xfer.sv
module dma_active_xfer
    import dma_desc_pkg::*;
#(
    parameter int ADDR_STEP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [CNT_W-1:0] p_cnt,
    input  logic [AW-1:0]    p_addr,
    input  logic             p_dir,
    input  logic             word,
    input  logic             abort,
    output act_s             act,
    output logic             done_evt
);

    localparam logic [AW-1:0] STEP = AW'(ADDR_STEP);

    act_s act_d, act_q;

    always_comb begin
        act_d      = act_q;
        act_d.load = 1'b0;
        done_evt   = 1'b0;
        if (abort) begin
            act_d.busy = 1'b0;
        end else if (take) begin
            act_d.busy = (p_cnt != '0);
            act_d.cnt  = p_cnt;
            act_d.addr = p_addr;
            act_d.dir  = p_dir;
            act_d.load = 1'b1;
            done_evt   = (p_cnt == '0);
        end else if (act_q.busy && word) begin
            act_d.cnt  = act_q.cnt - 1'b1;
            act_d.addr = act_q.addr + STEP;
            if (act_q.cnt == CNT_W'(1)) begin
                act_d.busy = 1'b0;
                done_evt   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= act_d;
    end

    assign act = act_q;

endmodule

// File: rtl/dma_irq_unit.sv
module dma_irq_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_take,
    input  logic set_done,
    input  logic clr,
    input  logic wr_cfg,
    input  logic cfg_gie,
    output logic flag,
    output logic gie,
    output logic irq
);

    import dma_desc_pkg::*;

    irq_s irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (clr)
            irq_d.flag = 1'b0;
        if (set_take || set_done)
            irq_d.flag = 1'b1;
        if (wr_cfg)
            irq_d.gie = cfg_gie;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign flag = irq_q.flag;
    assign gie  = irq_q.gie;
    assign irq  = irq_q.flag & irq_q.gie;

endmodule

// File: rtl/dma_desc_ctrl.sv
module dma_desc_ctrl
    import dma_desc_pkg::*;
#(
    parameter int ADDR_STEP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             xfer_load,
    output logic [CNT_W-1:0] xfer_count,
    output logic [AW-1:0]    xfer_addr,
    input  logic             xfer_word,
    output logic             xfer_rd,
    output logic             irq
);

    pend_s pend;
    act_s  act;

    logic wr_ctrl, wr_naddr, wr_stat, wr_cfg;
    logic abort_req, take, done_evt;
    logic irq_flag, irq_gie, irq_clr, set_any;
    logic pend_valid, busy;
    logic [AW-1:0] next_addr;
    logic [31:0] ctrl_rd;

    assign wr_ctrl   = reg_wr && (reg_addr == RA_CTRL);
    assign wr_naddr  = reg_wr && (reg_addr == RA_NADDR);
    assign wr_stat   = reg_wr && (reg_addr == RA_ISTAT);
    assign wr_cfg    = reg_wr && (reg_addr == RA_ICFG);
    assign abort_req = wr_ctrl && reg_wdata[B_ABORT];

    assign pend_valid = pend.valid;
    assign next_addr  = pend.addr;
    assign busy       = act.busy;
    assign take       = pend.valid && !act.busy;

    dma_pend_slot u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_ctrl),
        .wr_naddr  (wr_naddr),
        .w_start   (reg_wdata[B_START]),
        .w_dir     (reg_wdata[B_DIR]),
        .w_cnt     (reg_wdata[CNT_W-1:0]),
        .w_en_take (reg_wdata[B_EN_TAKE]),
        .w_en_page (reg_wdata[B_EN_PAGE]),
        .w_en_done (reg_wdata[B_EN_DONE]),
        .w_addr    (reg_wdata[AW-1:0]),
        .abort     (abort_req),
        .take      (take),
        .pend      (pend)
    );

    dma_active_xfer #(.ADDR_STEP(ADDR_STEP)) u_act (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take && !abort_req),
        .p_cnt    (pend.cnt),
        .p_addr   (pend.addr),
        .p_dir    (pend.dir),
        .word     (xfer_word),
        .abort    (abort_req),
        .act      (act),
        .done_evt (done_evt)
    );

    assign irq_clr = wr_stat && reg_wdata[0];
    assign set_any = (take && !abort_req && pend.en_take) || (done_evt && pend.en_done);

    dma_irq_unit u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_take (take && !abort_req && pend.en_take),
        .set_done (done_evt && pend.en_done),
        .clr      (irq_clr),
        .wr_cfg   (wr_cfg),
        .cfg_gie  (reg_wdata[0]),
        .flag     (irq_flag),
        .gie      (irq_gie),
        .irq      (irq)
    );

    always_comb begin
        ctrl_rd            = '0;
        ctrl_rd[B_EN_TAKE] = pend.en_take;
        ctrl_rd[B_IDLE]    = !act.busy;
        ctrl_rd[B_START]   = !pend.valid;
        ctrl_rd[B_EN_PAGE] = pend.en_page;
        ctrl_rd[B_EN_DONE] = pend.en_done;
        ctrl_rd[B_DIR]     = pend.dir;
        ctrl_rd[CNT_W-1:0] = pend.cnt;
    end

    always_comb begin
        case (reg_slot_e'(reg_addr))
            RA_CTRL:  reg_rdata = ctrl_rd;
            RA_NADDR: reg_rdata = pend.addr;
            RA_ISTAT: reg_rdata = {31'b0, irq_flag};
            default:  reg_rdata = {31'b0, irq_gie};
        endcase
    end

    assign xfer_load  = act.load;
    assign xfer_count = act.cnt;
    assign xfer_addr  = act.addr;
    assign xfer_rd    = act.dir;

endmodule

// File: rtl/dma_desc_ctrl_chk.sv
module dma_desc_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pend_valid,
    input logic        busy,
    input logic        take,
    input logic        abort_req,
    input logic [31:0] next_addr,
    input logic        xfer_load,
    input logic        xfer_word,
    input logic [15:0] xfer_count,
    input logic        irq,
    input logic        irq_clr,
    input logic        set_any
);

    assert_slot_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid && !take && !abort_req) |=> $stable(next_addr));

    assert_handover_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid && !busy && !abort_req) |=> xfer_load);

    assert_load_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_load |=> !xfer_load);

    assert_count_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_word && !take && !abort_req) |=> $stable(xfer_count));

    assert_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && xfer_word && xfer_count == 16'd1 && !abort_req) |=> !busy);

    assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> (!busy && !pend_valid && !xfer_load));

    assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !set_any) |=> !irq);

endmodule

bind dma_desc_ctrl dma_desc_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_valid (pend_valid),
    .busy       (busy),
    .take       (take),
    .abort_req  (abort_req),
    .next_addr  (next_addr),
    .xfer_load  (xfer_load),
    .xfer_word  (xfer_word),
    .xfer_count (xfer_count),
    .irq        (irq),
    .irq_clr    (irq_clr),
    .set_any    (set_any)
);

// File: tb/tb_dma_desc_ctrl.sv
`timescale 1ns/1ps
module tb_dma_desc_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        xfer_load;
    logic [15:0] xfer_count;
    logic [31:0] xfer_addr;
    logic        xfer_word = 1'b0;
    logic        xfer_rd;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dma_desc_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_load(xfer_load),
        .xfer_count(xfer_count), .xfer_addr(xfer_addr), .xfer_word(xfer_word),
        .xfer_rd(xfer_rd), .irq(irq)
    );

    // vector: {count, base address, dir, take enable, done enable}
    localparam logic [50:0] VEC [4] = '{
        {16'd3, 32'h1000_0000, 1'b1, 1'b1, 1'b0},
        {16'd5, 32'h2000_0040, 1'b0, 1'b0, 1'b1},
        {16'd1, 32'hFFFF_FFF8, 1'b1, 1'b1, 1'b1},
        {16'd0, 32'h0000_0100, 1'b0, 1'b0, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic words(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            xfer_word = 1'b1;
            @(negedge clk);
            xfer_word = 1'b0;
        end
    endtask

    function automatic logic [31:0] ctl(input bit et, input bit st, input bit ep,
                                        input bit ed, input bit ab, input bit dr,
                                        input logic [15:0] c);
        return {et, 1'b0, st, ep, ed, ab, dr, 9'b0, c};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, r); check("R1 ctrl", r, 32'h6000_0000);
        check("R1 irq", {31'b0, irq}, 32'd0);
        check("R1 load", {31'b0, xfer_load}, 32'd0);
        check("R1 count", {16'b0, xfer_count}, 32'd0);

        // R5 word pulse while idle is ignored
        words(2);
        check("R5 idle count", {16'b0, xfer_count}, 32'd0);
        check("R5 idle addr", xfer_addr, 32'd0);

        wr(2'd3, 32'd1);

        for (int v = 0; v < 4; v++) begin
            logic [15:0] c;
            logic [31:0] b;
            logic dr, et, ed;
            {c, b, dr, et, ed} = VEC[v];
            wr(2'd1, b);
            wr(2'd0, ctl(et, 1'b1, 1'b0, ed, 1'b0, dr, c));
            rd(2'd0, r); check("R2 slot busy", {31'b0, r[29]}, 32'd0);
            check("R2 staged count", {16'b0, r[15:0]}, {16'b0, c});
            @(negedge clk);
            check("R4 load pulse", {31'b0, xfer_load}, 32'd1);
            check("R4 count", {16'b0, xfer_count}, {16'b0, c});
            check("R4 addr", xfer_addr, b);
            check("R4 dir", {31'b0, xfer_rd}, {31'b0, dr});
            rd(2'd0, r); check("R4 slot free", {31'b0, r[29]}, 32'd1);
            rd(2'd2, r); check("R8 flag after take", r, {31'b0, et | (ed & (c == 0))});
            words(int'(c));
            rd(2'd0, r); check("R6 idle after run", {31'b0, r[30]}, 32'd1);
            check("R5 final count", {16'b0, xfer_count}, 32'd0);
            check("R5 final addr", xfer_addr, b + 32'd4 * c);
            rd(2'd2, r); check("R8 flag after run", r, {31'b0, et | ed});
            check("R9 irq", {31'b0, irq}, {31'b0, et | ed});
            wr(2'd2, 32'd1);
            check("R8 cleared", {31'b0, irq}, 32'd0);
        end

        // R3 / R6 queueing behind a running transfer
        wr(2'd1, 32'h0000_A000);
        wr(2'd0, ctl(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'd4));
        @(negedge clk);
        check("R4 run A", {16'b0, xfer_count}, 32'd4);
        wr(2'd1, 32'h0000_B000);
        wr(2'd0, ctl(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 16'd2));
        rd(2'd0, r); check("R3 waiting", {31'b0, r[29]}, 32'd0);
        wr(2'd1, 32'h0000_C000);
        wr(2'd0, ctl(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'd7));
        rd(2'd1, r); check("R3 addr locked", r, 32'h0000_B000);
        rd(2'd0, r); check("R3 count locked", {16'b0, r[15:0]}, 32'd2);
        check("R3 dir locked", {31'b0, r[25]}, 32'd1);
        check("R10 enables while locked", {29'b0, r[31], r[28], r[27]}, 32'd7);
        rd(2'd0, r); check("R6 busy", {31'b0, r[30]}, 32'd0);
        words(4);
        check("R6 no load yet", {31'b0, xfer_load}, 32'd0);
        @(negedge clk);
        check("R6 queued load", {31'b0, xfer_load}, 32'd1);
        check("R6 queued count", {16'b0, xfer_count}, 32'd2);
        check("R6 queued addr", xfer_addr, 32'h0000_B000);
        words(2);
        wr(2'd2, 32'd1);

        // R7 abort
        wr(2'd1, 32'h0000_D000);
        wr(2'd0, ctl(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'd5));
        @(negedge clk);
        wr(2'd0, ctl(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'd3));
        words(2);
        wr(2'd0, ctl(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'd0));
        rd(2'd0, r);
        check("R7 free", {31'b0, r[29]}, 32'd1);
        check("R7 idle", {31'b0, r[30]}, 32'd1);
        check("R7 abort bit", {31'b0, r[26]}, 32'd0);
        @(negedge clk);
        check("R7 no load", {31'b0, xfer_load}, 32'd0);
        words(1);
        check("R7 count held", {16'b0, xfer_count}, 32'd3);
        rd(2'd2, r); check("R7 no event", r, 32'd0);

        // R8 / R9 gating and clear rules
        wr(2'd3, 32'd0);
        wr(2'd1, 32'h0000_E000);
        wr(2'd0, ctl(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'd1));
        @(negedge clk);
        words(1);
        rd(2'd2, r); check("R8 done set", r, 32'd1);
        check("R9 gated off", {31'b0, irq}, 32'd0);
        wr(2'd3, 32'd1);
        check("R9 gated on", {31'b0, irq}, 32'd1);
        wr(2'd2, 32'd0);
        check("R8 write zero keeps", {31'b0, irq}, 32'd1);
        wr(2'd2, 32'd1);
        check("R8 write one clears", {31'b0, irq}, 32'd0);

        // R10 enable readback while idle
        wr(2'd0, ctl(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'd9));
        rd(2'd0, r); check("R10 readback", r, 32'hF000_0009);
        wr(2'd0, ctl(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'd0));
        rd(2'd0, r); check("R10 readback 2", r, 32'h6800_0000);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule